// File: doc/BRIEF.md
# Privileged Status and Exception-Return Control

This block holds the privileged machine state of a 32-bit core: the processor status word, the cause word, the three return-address registers (exception, error and debug), the exception base, the user hardware-register enable mask and a debug control word. The pipeline reaches these registers through a single indexed read/write port. Every write passes through a fixed mask, so bits that are not implemented stay at zero and read-only bits keep their value.

The block also takes single-cycle strobes from the pipeline. These cover exception return, debug return, interrupt disable, interrupt enable, interrupt polling and exception entry. From its state it produces the current privilege flags, the target PC of a return, a pulse that breaks a pending load-linked reservation, the status value before an interrupt disable or enable, and three requests: interrupt take, coprocessor-unusable and reserved-instruction. Writes land on the next rising clock edge. All request and flag outputs are combinational from the current state and the inputs.

The pipeline is expected to issue at most one command per cycle. If commands collide, return, disable, enable and exception-entry strobes take precedence over a register write, and that write is dropped.

Top module: `priv_ctl`

## Requirements
- R1: A Status write (select 0) changes only the bits in mask 0xF878FF17; every other Status bit keeps its value and reads 0 from reset. Field positions: IE bit 0, EXL bit 1, ERL bit 2, UM bit 4, interrupt mask bits 15:8, CU0 bit 28.
- R2: `user_mode_o` is 1 exactly when EXL=0, ERL=0, debug mode is off and UM=1.
- R3: On `eret_i`, if ERL=1 then `ret_pc_o` is the error return register (select 3) and ERL clears; otherwise `ret_pc_o` is the exception return register (select 2) and EXL clears.
- R4: On `deret_i`, `ret_pc_o` is the debug return register (select 4) and debug mode turns off; `ll_clear_o` is 1 during either kind of return and 0 otherwise.
- R5: On `di_i` or `ei_i`, `old_status_o` shows Status before the strobe; IE is then cleared or set respectively.
- R6: `irq_take_o` is 1 on `irq_chk_i` when EXL=0, ERL=0, debug mode is off, IE=1 and some Cause pending bit 15:8 meets its Status mask bit 15:8. When it fires, the Cause exception-code field (bits 6:2) clears. `exc_wr_i` loads that field from `exc_code_i` and sets EXL.
- R7: A Cause write (select 1) changes only the bits in mask 0x00C00300. Cause bits 15:10 read the live `hw_irq_i` lines.
- R8: An EBase write (select 5) stores 0x80000000 OR (data AND 0x3FFFF000). Every other bit reads 0.
- R9: A register access in user mode with CU0=0 raises `cpu_unusable_o`, and any write in that access is dropped.
- R10: A hardware-register read of index n (0 to 3) raises `hwr_ri_o` only in user mode when enable bit n and CU0 are both 0.
- R11: A write to the enable register (select 6) keeps only data bits 3:0; bits 31:4 read 0.
- R12: A write to the debug word (select 7) stores data AND 0x13300120. Data bit 30 turns debug mode on (1) or off (0). Bit 30 reads 1 whenever debug mode is on.
- R13: Reset gives Status 0x00000004 (ERL set; EXL, IE and UM clear), debug mode off, EBase 0x80000000 and every other register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_acc_i | input | 1 | Register port access this cycle |
| reg_wr_i | input | 1 | Access is a write |
| reg_sel_i | input | 3 | Register select (0 Status, 1 Cause, 2 EPC, 3 ErrorEPC, 4 DEPC, 5 EBase, 6 enable, 7 debug) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| eret_i | input | 1 | Exception return strobe |
| deret_i | input | 1 | Debug return strobe |
| di_i | input | 1 | Interrupt disable strobe |
| ei_i | input | 1 | Interrupt enable strobe |
| irq_chk_i | input | 1 | Interrupt poll strobe |
| exc_wr_i | input | 1 | Exception entry: load code, set EXL |
| exc_code_i | input | 5 | Exception code for entry |
| hw_irq_i | input | 6 | Hardware interrupt lines |
| hwr_rd_i | input | 1 | Hardware-register read request |
| hwr_idx_i | input | 2 | Hardware-register index |
| user_mode_o | output | 1 | Current user-mode flag |
| debug_mode_o | output | 1 | Current debug-mode flag |
| ret_pc_o | output | 32 | Target PC of the return this cycle |
| ll_clear_o | output | 1 | Break the load-linked reservation |
| old_status_o | output | 32 | Status before a disable or enable |
| irq_take_o | output | 1 | Interrupt take request |
| cpu_unusable_o | output | 1 | Coprocessor-unusable request |
| hwr_ri_o | output | 1 | Reserved-instruction request |

## Verification
The assertions check on every cycle that the unimplemented Status bits and the fixed EBase bits never change, that user mode, interrupt take, coprocessor-unusable and reserved-instruction never appear outside their privilege conditions, and that returns, disables, enables and interrupt takes leave the right Status and Cause bits one cycle later. The bench scenarios show the rest: the values read back after masked writes, the PC chosen by each return, the old Status returned by a disable or enable, and that a write dropped in user mode leaves no trace once privilege is regained.

// File: rtl/priv_ctl_pkg.sv
package priv_ctl_pkg;

   localparam int unsigned XLEN = 32;

   // register selects seen on the access port
   typedef enum logic [2:0] {
      RSEL_STATUS = 3'd0,
      RSEL_CAUSE  = 3'd1,
      RSEL_EPC    = 3'd2,
      RSEL_ERRPC  = 3'd3,
      RSEL_DBGPC  = 3'd4,
      RSEL_EBASE  = 3'd5,
      RSEL_HWREN  = 3'd6,
      RSEL_DEBUG  = 3'd7
   } rsel_e;

   // status word bit positions
   localparam int unsigned ST_IE    = 0;
   localparam int unsigned ST_EXL   = 1;
   localparam int unsigned ST_ERL   = 2;
   localparam int unsigned ST_UM    = 4;
   localparam int unsigned ST_IM_LO = 8;
   localparam int unsigned ST_CU0   = 28;

   // cause word bit positions
   localparam int unsigned CA_CODE_LO = 2;
   localparam int unsigned CA_CODE_W  = 5;
   localparam int unsigned CA_IP_LO   = 8;
   localparam int unsigned CA_HWIP_LO = 10;
   localparam int unsigned IP_W       = 8;

   // debug word mode bit
   localparam int unsigned DBG_DM = 30;

endpackage

// File: rtl/priv_level_eval.sv
module priv_level_eval
   import priv_ctl_pkg::*;
(
   input  logic            exl_i,
   input  logic            erl_i,
   input  logic            dm_i,
   input  logic            um_i,
   input  logic            ie_i,
   input  logic [IP_W-1:0] im_i,
   input  logic [IP_W-1:0] ip_i,
   output logic            user_o,
   output logic            irq_ok_o
);

   logic base_lvl;

   assign base_lvl = ~exl_i & ~erl_i & ~dm_i;
   assign user_o   = base_lvl & um_i;
   assign irq_ok_o = base_lvl & ie_i & (|(im_i & ip_i));

endmodule

// File: rtl/priv_hwr_gate.sv
module priv_hwr_gate #(
   parameter int unsigned NUM = 4,
   parameter int unsigned IW  = 2
) (
   input  logic           rd_i,
   input  logic [IW-1:0]  idx_i,
   input  logic           user_i,
   input  logic           cu0_i,
   input  logic [NUM-1:0] en_i,
   output logic           ri_o
);

   localparam int unsigned SLOTS = 1 << IW;

   logic [SLOTS-1:0] grant;

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         if (k < NUM) begin : g_real
            assign grant[k] = ~user_i | en_i[k] | cu0_i;
         end else begin : g_none
            assign grant[k] = 1'b0;
         end
      end
   endgenerate

   assign ri_o = rd_i & ~grant[idx_i];

endmodule

// File: rtl/priv_ret_sel.sv
module priv_ret_sel #(
   parameter int unsigned W = 32
) (
   input  logic         eret_i,
   input  logic         deret_i,
   input  logic         erl_i,
   input  logic [W-1:0] epc_i,
   input  logic [W-1:0] errpc_i,
   input  logic [W-1:0] dbgpc_i,
   output logic [W-1:0] pc_o,
   output logic         ll_clr_o
);

   always_comb begin
      pc_o = '0;
      if (deret_i)
         pc_o = dbgpc_i;
      else if (eret_i)
         pc_o = erl_i ? errpc_i : epc_i;
   end

   assign ll_clr_o = eret_i | deret_i;

endmodule

// File: rtl/priv_ctl.sv
module priv_ctl
   import priv_ctl_pkg::*;
#(
   parameter int unsigned HW_IRQS      = 6,
   parameter int unsigned HWR_NUM      = 4,
   parameter logic [31:0] STATUS_WMASK = 32'hF878_FF17,
   parameter logic [31:0] CAUSE_WMASK  = 32'h00C0_0300,
   parameter logic [31:0] EBASE_WMASK  = 32'h3FFF_F000,
   parameter logic [31:0] EBASE_FIXED  = 32'h8000_0000,
   parameter logic [31:0] DEBUG_WMASK  = 32'h1330_0120,
   localparam int unsigned HWR_IW      = (HWR_NUM > 1) ? $clog2(HWR_NUM) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_acc_i,
   input  logic               reg_wr_i,
   input  logic [2:0]         reg_sel_i,
   input  logic [XLEN-1:0]    reg_wdata_i,
   output logic [XLEN-1:0]    reg_rdata_o,
   input  logic               eret_i,
   input  logic               deret_i,
   input  logic               di_i,
   input  logic               ei_i,
   input  logic               irq_chk_i,
   input  logic               exc_wr_i,
   input  logic [CA_CODE_W-1:0] exc_code_i,
   input  logic [HW_IRQS-1:0] hw_irq_i,
   input  logic               hwr_rd_i,
   input  logic [HWR_IW-1:0]  hwr_idx_i,
   output logic               user_mode_o,
   output logic               debug_mode_o,
   output logic [XLEN-1:0]    ret_pc_o,
   output logic               ll_clear_o,
   output logic [XLEN-1:0]    old_status_o,
   output logic               irq_take_o,
   output logic               cpu_unusable_o,
   output logic               hwr_ri_o
);

   localparam logic [XLEN-1:0] STATUS_RST = XLEN'(1) << ST_ERL;

   // elaboration-time parameter checks
   generate
      if (HW_IRQS < 1 || HW_IRQS > IP_W - (CA_HWIP_LO - CA_IP_LO)) begin : g_bad_irqs
         $error("priv_ctl: HW_IRQS out of range");
      end
      if (HWR_NUM < 1 || HWR_NUM > XLEN) begin : g_bad_hwr
         $error("priv_ctl: HWR_NUM out of range");
      end
      if ((EBASE_WMASK & EBASE_FIXED) != '0) begin : g_bad_ebase
         $error("priv_ctl: EBase fixed and writable bits overlap");
      end
   endgenerate

   // state
   logic [XLEN-1:0]      status_q, status_d;
   logic [XLEN-1:0]      cause_q,  cause_d;
   logic [CA_CODE_W-1:0] code_q,   code_d;
   logic [XLEN-1:0]      epc_q, errpc_q, dbgpc_q, ebase_q, dbgw_q;
   logic [HWR_NUM-1:0]   hwren_q;
   logic                 dm_q, dm_d;

   rsel_e                sel;
   logic                 strobe_any;
   logic                 wr_go;
   logic [XLEN-1:0]      hw_ip;
   logic [XLEN-1:0]      cause_rd;
   logic                 irq_ok;

   assign sel        = rsel_e'(reg_sel_i);
   assign strobe_any = eret_i | deret_i | di_i | ei_i | exc_wr_i;
   assign wr_go      = reg_acc_i & reg_wr_i & ~cpu_unusable_o & ~strobe_any;
   assign hw_ip      = XLEN'(hw_irq_i) << CA_HWIP_LO;
   assign cause_rd   = cause_q | hw_ip | (XLEN'(code_q) << CA_CODE_LO);

   // privilege and interrupt eligibility
   priv_level_eval u_level (
      .exl_i    (status_q[ST_EXL]),
      .erl_i    (status_q[ST_ERL]),
      .dm_i     (dm_q),
      .um_i     (status_q[ST_UM]),
      .ie_i     (status_q[ST_IE]),
      .im_i     (status_q[ST_IM_LO +: IP_W]),
      .ip_i     (cause_rd[CA_IP_LO +: IP_W]),
      .user_o   (user_mode_o),
      .irq_ok_o (irq_ok)
   );

   // hardware-register read gate
   priv_hwr_gate #(
      .NUM (HWR_NUM),
      .IW  (HWR_IW)
   ) u_hwr (
      .rd_i   (hwr_rd_i),
      .idx_i  (hwr_idx_i),
      .user_i (user_mode_o),
      .cu0_i  (status_q[ST_CU0]),
      .en_i   (hwren_q),
      .ri_o   (hwr_ri_o)
   );

   // return target selection
   priv_ret_sel #(
      .W (XLEN)
   ) u_ret (
      .eret_i   (eret_i),
      .deret_i  (deret_i),
      .erl_i    (status_q[ST_ERL]),
      .epc_i    (epc_q),
      .errpc_i  (errpc_q),
      .dbgpc_i  (dbgpc_q),
      .pc_o     (ret_pc_o),
      .ll_clr_o (ll_clear_o)
   );

   assign debug_mode_o   = dm_q;
   assign old_status_o   = status_q;
   assign irq_take_o     = irq_chk_i & irq_ok;
   assign cpu_unusable_o = reg_acc_i & user_mode_o & ~status_q[ST_CU0];

   // next status
   always_comb begin
      status_d = status_q;
      if (eret_i) begin
         if (status_q[ST_ERL]) status_d[ST_ERL] = 1'b0;
         else                  status_d[ST_EXL] = 1'b0;
      end else if (deret_i) begin
         status_d = status_q;
      end else if (di_i) begin
         status_d[ST_IE] = 1'b0;
      end else if (ei_i) begin
         status_d[ST_IE] = 1'b1;
      end else if (exc_wr_i) begin
         status_d[ST_EXL] = 1'b1;
      end else if (wr_go && sel == RSEL_STATUS) begin
         status_d = (status_q & ~STATUS_WMASK) | (reg_wdata_i & STATUS_WMASK);
      end
   end

   // next cause and exception code
   always_comb begin
      cause_d = cause_q;
      code_d  = code_q;
      if (exc_wr_i)
         code_d = exc_code_i;
      else if (irq_take_o)
         code_d = '0;
      if (wr_go && sel == RSEL_CAUSE)
         cause_d = (cause_q & ~CAUSE_WMASK) | (reg_wdata_i & CAUSE_WMASK);
   end

   // next debug mode
   always_comb begin
      dm_d = dm_q;
      if (deret_i)
         dm_d = 1'b0;
      else if (wr_go && sel == RSEL_DEBUG)
         dm_d = reg_wdata_i[DBG_DM];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= STATUS_RST;
         cause_q  <= '0;
         code_q   <= '0;
         dm_q     <= 1'b0;
      end else begin
         status_q <= status_d;
         cause_q  <= cause_d;
         code_q   <= code_d;
         dm_q     <= dm_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_q   <= '0;
         errpc_q <= '0;
         dbgpc_q <= '0;
         ebase_q <= EBASE_FIXED;
         hwren_q <= '0;
         dbgw_q  <= '0;
      end else if (wr_go) begin
         unique case (sel)
            RSEL_EPC:   epc_q   <= reg_wdata_i;
            RSEL_ERRPC: errpc_q <= reg_wdata_i;
            RSEL_DBGPC: dbgpc_q <= reg_wdata_i;
            RSEL_EBASE: ebase_q <= EBASE_FIXED | (reg_wdata_i & EBASE_WMASK);
            RSEL_HWREN: hwren_q <= reg_wdata_i[HWR_NUM-1:0];
            RSEL_DEBUG: dbgw_q  <= reg_wdata_i & DEBUG_WMASK;
            default:    ;
         endcase
      end
   end

   // read mux
   always_comb begin
      unique case (sel)
         RSEL_STATUS: reg_rdata_o = status_q;
         RSEL_CAUSE:  reg_rdata_o = cause_rd;
         RSEL_EPC:    reg_rdata_o = epc_q;
         RSEL_ERRPC:  reg_rdata_o = errpc_q;
         RSEL_DBGPC:  reg_rdata_o = dbgpc_q;
         RSEL_EBASE:  reg_rdata_o = ebase_q;
         RSEL_HWREN:  reg_rdata_o = XLEN'(hwren_q);
         RSEL_DEBUG:  reg_rdata_o = dbgw_q | (XLEN'(dm_q) << DBG_DM);
         default:     reg_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/priv_ctl_chk.sv
module priv_ctl_chk
   import priv_ctl_pkg::*;
#(
   parameter logic [31:0] STATUS_WMASK = 32'hF878_FF17,
   parameter logic [31:0] EBASE_WMASK  = 32'h3FFF_F000,
   parameter logic [31:0] EBASE_FIXED  = 32'h8000_0000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [31:0]          status,
   input logic [31:0]          ebase,
   input logic [CA_CODE_W-1:0] code,
   input logic                 dm,
   input logic                 user_mode,
   input logic                 eret,
   input logic                 deret,
   input logic                 di,
   input logic                 ei,
   input logic                 exc_wr,
   input logic                 irq_take,
   input logic                 cpu_unusable,
   input logic                 hwr_ri
);

   AST_STATUS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~STATUS_WMASK) == '0); // R1

   AST_USER_NEEDS_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |-> (!status[ST_EXL] && !status[ST_ERL] && !dm && status[ST_UM])); // R2

   AST_ERET_DROPS_ERL: assert property (@(posedge clk) disable iff (!rst_n)
      (eret && status[ST_ERL]) |=> !status[ST_ERL]); // R3

   AST_ERET_DROPS_EXL: assert property (@(posedge clk) disable iff (!rst_n)
      (eret && !status[ST_ERL]) |=> (!status[ST_EXL] && !status[ST_ERL])); // R3

   AST_DERET_LEAVES_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
      deret |=> !dm); // R4

   AST_DI_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      di |=> !status[ST_IE]); // R5

   AST_EI_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      ei |=> status[ST_IE]); // R5

   AST_IRQ_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (status[ST_IE] && !status[ST_EXL] && !status[ST_ERL] && !dm)); // R6

   AST_IRQ_CLEARS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && !exc_wr) |=> (code == '0)); // R6

   AST_EBASE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (ebase & ~EBASE_WMASK) == EBASE_FIXED); // R8

   AST_CPU_UNUSABLE_USER: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_unusable |-> (user_mode && !status[ST_CU0])); // R9

   AST_HWR_RI_USER: assert property (@(posedge clk) disable iff (!rst_n)
      hwr_ri |-> (user_mode && !status[ST_CU0])); // R10

endmodule

bind priv_ctl priv_ctl_chk #(
   .STATUS_WMASK (STATUS_WMASK),
   .EBASE_WMASK  (EBASE_WMASK),
   .EBASE_FIXED  (EBASE_FIXED)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .status       (status_q),
   .ebase        (ebase_q),
   .code         (code_q),
   .dm           (dm_q),
   .user_mode    (user_mode_o),
   .eret         (eret_i),
   .deret        (deret_i),
   .di           (di_i),
   .ei           (ei_i),
   .exc_wr       (exc_wr_i),
   .irq_take     (irq_take_o),
   .cpu_unusable (cpu_unusable_o),
   .hwr_ri       (hwr_ri_o)
);

// File: tb/test_priv_ctl.sv
`timescale 1ns/1ps
module test_priv_ctl;

   localparam logic [31:0] SM  = 32'hF878_FF17;
   localparam logic [31:0] CM  = 32'h00C0_0300;
   localparam logic [31:0] EM  = 32'h3FFF_F000;
   localparam logic [31:0] DBM = 32'h1330_0120;

   localparam int C_WR = 0, C_RD = 1, C_ERET = 2, C_DERET = 3, C_DI = 4,
                  C_EI = 5, C_IRQ = 6, C_EXC = 7, C_HWR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_acc_i = 0, reg_wr_i = 0;
   logic [2:0]  reg_sel_i = 0;
   logic [31:0] reg_wdata_i = 0;
   logic [31:0] reg_rdata_o;
   logic        eret_i = 0, deret_i = 0, di_i = 0, ei_i = 0, irq_chk_i = 0, exc_wr_i = 0;
   logic [4:0]  exc_code_i = 0;
   logic [5:0]  hw_irq_i = 0;
   logic        hwr_rd_i = 0;
   logic [1:0]  hwr_idx_i = 0;
   logic        user_mode_o, debug_mode_o, ll_clear_o, irq_take_o, cpu_unusable_o, hwr_ri_o;
   logic [31:0] ret_pc_o, old_status_o;

   always #2.5 clk = ~clk;

   priv_ctl i_priv_ctl (
      .clk(clk), .rst_n(rst_n),
      .reg_acc_i(reg_acc_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .eret_i(eret_i), .deret_i(deret_i), .di_i(di_i), .ei_i(ei_i),
      .irq_chk_i(irq_chk_i), .exc_wr_i(exc_wr_i), .exc_code_i(exc_code_i),
      .hw_irq_i(hw_irq_i), .hwr_rd_i(hwr_rd_i), .hwr_idx_i(hwr_idx_i),
      .user_mode_o(user_mode_o), .debug_mode_o(debug_mode_o),
      .ret_pc_o(ret_pc_o), .ll_clear_o(ll_clear_o), .old_status_o(old_status_o),
      .irq_take_o(irq_take_o), .cpu_unusable_o(cpu_unusable_o), .hwr_ri_o(hwr_ri_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model state
   logic [31:0] m_st, m_ca, m_epc, m_err, m_dpc, m_eb, m_dbg;
   logic [4:0]  m_code;
   logic [3:0]  m_hwr;
   logic        m_dm;

   function automatic logic f_um();
      return !m_st[1] && !m_st[2] && !m_dm && m_st[4];
   endfunction

   function automatic logic f_irq(input logic [5:0] hw);
      logic [7:0] ip;
      ip = {hw, m_ca[9:8]};
      return !m_st[1] && !m_st[2] && !m_dm && m_st[0] && ((ip & m_st[15:8]) != 0);
   endfunction

   function automatic logic [31:0] f_read(input int sel, input logic [5:0] hw);
      case (sel)
         0: return m_st;
         1: return m_ca | (32'(m_code) << 2) | (32'(hw) << 10);
         2: return m_epc;
         3: return m_err;
         4: return m_dpc;
         5: return m_eb;
         6: return 32'(m_hwr);
         default: return m_dbg | (32'(m_dm) << 30);
      endcase
   endfunction

   function automatic string f_tag(input int sel);
      case (sel)
         0: return "R1";
         1: return "R7";
         2, 3: return "R3";
         4: return "R4";
         5: return "R8";
         6: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle();
      reg_acc_i = 0; reg_wr_i = 0; eret_i = 0; deret_i = 0; di_i = 0; ei_i = 0;
      irq_chk_i = 0; exc_wr_i = 0; hwr_rd_i = 0;
   endtask

   // one command per cycle: drive at negedge, check before posedge, advance model
   task automatic run(input int cmd, input int sel, input logic [31:0] data);
      logic blk;
      logic take;
      @(negedge clk);
      idle();
      hw_irq_i = 6'($urandom);
      case (cmd)
         C_WR:    begin reg_acc_i = 1; reg_wr_i = 1; reg_sel_i = 3'(sel); reg_wdata_i = data; end
         C_RD:    begin reg_acc_i = 1; reg_sel_i = 3'(sel); end
         C_ERET:  eret_i = 1;
         C_DERET: deret_i = 1;
         C_DI:    di_i = 1;
         C_EI:    ei_i = 1;
         C_IRQ:   irq_chk_i = 1;
         C_EXC:   begin exc_wr_i = 1; exc_code_i = data[4:0]; end
         default: begin hwr_rd_i = 1; hwr_idx_i = 2'(sel); end
      endcase
      #1;
      chk("R2 user_mode", 32'(user_mode_o), 32'(f_um()));
      chk("R12 debug_mode", 32'(debug_mode_o), 32'(m_dm));
      chk("R4 ll_clear", 32'(ll_clear_o), 32'(cmd == C_ERET || cmd == C_DERET));
      blk = (cmd == C_WR || cmd == C_RD) && f_um() && !m_st[28];
      if (cmd == C_WR || cmd == C_RD) chk("R9 cpu_unusable", 32'(cpu_unusable_o), 32'(blk));
      if (cmd == C_RD && !blk) chk(f_tag(sel), reg_rdata_o, f_read(sel, hw_irq_i));
      take = f_irq(hw_irq_i);
      chk("R6 irq_take", 32'(irq_take_o), 32'((cmd == C_IRQ) && take));
      chk("R10 hwr_ri", 32'(hwr_ri_o),
          32'((cmd == C_HWR) && f_um() && !m_hwr[sel[1:0]] && !m_st[28]));
      // model update
      case (cmd)
         C_WR: if (!blk) begin
            case (sel)
               0: m_st = (m_st & ~SM) | (data & SM);
               1: m_ca = (m_ca & ~CM) | (data & CM);
               2: m_epc = data;
               3: m_err = data;
               4: m_dpc = data;
               5: m_eb = 32'h8000_0000 | (data & EM);
               6: m_hwr = data[3:0];
               default: begin m_dbg = data & DBM; m_dm = data[30]; end
            endcase
         end
         C_ERET: begin
            if (m_st[2]) begin chk("R3 eret pc (ERL)", ret_pc_o, m_err); m_st[2] = 0; end
            else begin chk("R3 eret pc (EXL)", ret_pc_o, m_epc); m_st[1] = 0; end
         end
         C_DERET: begin chk("R4 deret pc", ret_pc_o, m_dpc); m_dm = 0; end
         C_DI: begin chk("R5 di old status", old_status_o, m_st); m_st[0] = 0; end
         C_EI: begin chk("R5 ei old status", old_status_o, m_st); m_st[0] = 1; end
         C_IRQ: if (take) m_code = 0;
         C_EXC: begin m_code = data[4:0]; m_st[1] = 1; end
         default: ;
      endcase
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      m_st = 32'h4; m_ca = 0; m_epc = 0; m_err = 0; m_dpc = 0; m_eb = 32'h8000_0000;
      m_dbg = 0; m_code = 0; m_hwr = 0; m_dm = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R13: reset state
      for (int s = 0; s < 8; s++) run(C_RD, s, 0);

      // R1, R7, R8, R11, R12: all-ones writes through the masks
      for (int s = 0; s < 8; s++) begin
         run(C_WR, s, 32'hFFFF_FFFF);
         run(C_RD, s, 0);
      end
      run(C_DERET, 0, 0);              // R4: leave debug mode
      run(C_WR, 0, 32'h0000_0000);     // R1
      run(C_WR, 7, 32'h4000_0000);     // R12: enter debug mode
      run(C_RD, 7, 0);
      run(C_WR, 2, 32'h1234_5678);
      run(C_WR, 3, 32'h9ABC_DEF0);
      run(C_WR, 4, 32'h0BAD_F00D);
      run(C_DERET, 0, 0);              // R4

      // R3: return with ERL set, then with only EXL set
      run(C_WR, 0, 32'h0000_0006);
      run(C_ERET, 0, 0);
      run(C_ERET, 0, 0);
      run(C_RD, 0, 0);

      // R6: interrupt take clears the code
      run(C_EXC, 0, 32'h0000_001F);
      run(C_WR, 0, 32'h0000_FF01);
      run(C_ERET, 0, 0);
      run(C_WR, 1, 32'h0000_0300);
      run(C_IRQ, 0, 0);
      run(C_RD, 1, 0);

      // R9, R10: user mode without CU0
      run(C_WR, 6, 32'h0000_0005);
      run(C_WR, 0, 32'h0000_0010);
      run(C_WR, 2, 32'hDEAD_BEEF);     // dropped
      for (int i = 0; i < 4; i++) run(C_HWR, i, 0);
      run(C_EXC, 0, 32'h3);            // escape via exception level
      run(C_RD, 2, 0);
      run(C_DI, 0, 0);                 // R5
      run(C_EI, 0, 0);

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int c;
         int s;
         logic [31:0] d;
         c = $urandom_range(0, 9);
         s = $urandom_range(0, 7);
         d = $urandom;
         if (c == 9) c = C_WR;
         if (c == C_WR && s == 7 && ($urandom_range(0, 3) != 0)) d[30] = 1'b0;
         if (c == C_HWR) s = s % 4;
         run(c, s, d);
      end

      @(negedge clk);
      idle();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule